// File: doc/BRIEF.md
# NAND Sector Hamming ECC Engine

This block protects one 512-byte NAND sector with a 24-bit single-error-correcting parity code. While the sector is moved to or from the flash, its bytes are fed in one per valid strobe. Two 12-bit parity groups build up over the 12-bit bit address of every data bit (nine byte-address bits above three bit-position bits). The two groups are packed side by side and inverted. An erased sector of all 0xFF bytes therefore yields an all-ones code, which matches an erased spare area.

For a write, the finished code is taken from `code_out` and stored as three bytes, least significant byte first. For a read, the sector is streamed through again and the code stored in the spare area is presented with a `check` pulse. The block XORs the two codes into a syndrome and classifies it. If a single data bit flipped, it repairs that byte in the sector buffer with a read-modify-write through its buffer port. It then reports the outcome with a one-cycle `done` pulse.

Top module: `nand_hamming_ecc`

## Requirements
- R1: While `rst_n` is low and after its release, `code_out` is 24'hFFFFFF, `done` is 0, `result` is 0, and neither `buf_rd_en` nor `buf_wr_en` is asserted.
- R2: For every accepted byte at index n (0..511, in order of acceptance), each data bit i has the 12-bit address {n, i}. Bit k of the high group (code bits 23:12) is the parity of all data bits whose address bit k is 1. Bit k of the low group (bits 11:0) is the parity of those whose address bit k is 0. `code_out` is the inverse of {high, low}, and byte 0 of the stored code is `code_out[7:0]`. It changes one clock after a byte is accepted.
- R3: A `start` pulse clears both groups and the byte count. Bytes seen before it have no effect on the code.
- R4: Valid bytes after the 512th since `start` are ignored and leave `code_out` unchanged.
- R5: A sector of all 0xFF bytes gives `code_out` = 24'hFFFFFF.
- R6: The syndrome is `code_out` XOR `stored_code`, sampled on the edge where `check` is high. A zero syndrome gives `result` 0 (clean), with `done` high in the cycle after the second following rising edge.
- R7: A single-data-bit error is detected when the low 12 syndrome bits XOR the high 12 equal 12'hFFF and the byte index (syndrome bits 23:15) is below 512. The bit number is syndrome bits 14:12. The block asserts `buf_rd_en` at that byte for one cycle. In the next cycle it asserts `buf_wr_en` with `buf_rdata` XOR (1 << bit). `done` follows one cycle later, with `result` 1, `err_byte` and `err_bit` set.
- R8: A syndrome with exactly one bit set gives `result` 2 (error in the stored code) with no buffer access. `done` arrives as in R6.
- R9: Every other nonzero syndrome, including a data-bit pattern whose byte index is 512 or more, gives `result` 3 (uncorrectable) with no buffer access.
- R10: `done` is high for exactly one cycle per check. `result`, `err_byte` and `err_bit` hold until the next outcome.
- R11: `err_byte` and `err_bit` are 0 whenever `result` is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Clears the parity groups and byte count for a new sector |
| in_valid | input | 1 | `in_byte` carries the next sector byte |
| in_byte | input | 8 | Sector data byte |
| code_out | output | 24 | Inverted packed parity code of the bytes so far |
| check | input | 1 | Compare `code_out` with `stored_code` and act on the result |
| stored_code | input | 24 | Code read back from the spare area |
| done | output | 1 | One-cycle pulse when a check has finished |
| result | output | 2 | 0 clean, 1 data bit fixed, 2 code bit in error, 3 uncorrectable |
| err_byte | output | 9 | Index of the repaired byte |
| err_bit | output | 3 | Bit number of the repaired bit |
| buf_rd_en | output | 1 | Read strobe to the sector buffer |
| buf_wr_en | output | 1 | Write strobe to the sector buffer |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_wdata | output | 8 | Repaired byte |
| buf_rdata | input | 8 | Buffer read data, valid one cycle after `buf_rd_en` |

## Verification
Random sectors separate a correct per-bit address parity from one that mixes up the groups, the byte order or the inversion. The erased sector and a sector restarted midway show the all-ones identity and the clearing. Single data-bit flips at random places and at the first and last bit of the sector check the byte and bit fields and the repaired buffer contents. Single flips in the stored code, pairs of data flips and a two-bit code pattern check that the other outcomes are kept apart and never touch the buffer.

// File: rtl/nand_ecc_pkg.sv
// Package: shared types and helpers for the sector ECC engine.
// Assumes the bit-position part of the bit address is three bits wide.
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        ECC_CLEAN      = 2'd0,
        ECC_DATA_FIXED = 2'd1,
        ECC_CODE_FIXED = 2'd2,
        ECC_UNCORR     = 2'd3
    } ecc_result_e;

    localparam int BIT_AW = 3;

    // Mask of the byte lanes whose lane number has bit k set.
    function automatic logic [7:0] lane_mask(input int k);
        logic [7:0] m;
        for (int i = 0; i < 8; i++) begin
            m[i] = ((i >> k) & 1) != 0;
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_parity_acc.sv
// Accumulates the two parity groups over a streamed sector.
// The high group collects bits whose address bit is 1, the low group
// those whose address bit is 0. Assumes one byte per valid cycle at most.
module ecc_parity_acc
    import nand_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int BYTE_AW      = $clog2(SECTOR_BYTES),
    parameter int GW           = BYTE_AW + BIT_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          in_valid,
    input  logic [7:0]    in_byte,
    output logic [GW-1:0] ones_par,
    output logic [GW-1:0] zeros_par
);

    localparam logic [BYTE_AW:0] SB = SECTOR_BYTES[BYTE_AW:0];

    logic [BYTE_AW:0] cnt_q;
    logic [GW-1:0]    ones_q, zeros_q;
    logic [GW-1:0]    ones_inc, zeros_inc;
    logic             byte_par;
    logic             take;

    assign byte_par = ^in_byte;
    assign take     = in_valid && !start && (cnt_q < SB);

    // Bit-position groups: parity of the lanes on each side of address bit k.
    for (genvar k = 0; k < BIT_AW; k++) begin : g_pos
        localparam logic [7:0] M = lane_mask(k);
        assign ones_inc[k]  = ^(in_byte & M);
        assign zeros_inc[k] = ^(in_byte & ~M);
    end

    // Byte-address groups: whole-byte parity routed by the byte index bit.
    for (genvar k = 0; k < BYTE_AW; k++) begin : g_addr
        assign ones_inc[BIT_AW+k]  = cnt_q[k] & byte_par;
        assign zeros_inc[BIT_AW+k] = ~cnt_q[k] & byte_par;
    end

    // Clear on reset or start, fold in each accepted byte otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            cnt_q   <= '0;
            ones_q  <= '0;
            zeros_q <= '0;
        end else if (take) begin
            cnt_q   <= cnt_q + 1'b1;
            ones_q  <= ones_q ^ ones_inc;
            zeros_q <= zeros_q ^ zeros_inc;
        end
    end

    assign ones_par  = ones_q;
    assign zeros_par = zeros_q;

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SB);  // R4
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == SB && !start) |=> ($stable(ones_q) && $stable(zeros_q)));  // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !start) |=> ($stable(ones_q) && $stable(zeros_q)));  // R2

endmodule

// File: rtl/ecc_syndrome_decode.sv
// Classifies a syndrome into one of four outcomes and extracts the
// byte index and bit number of a single data-bit error. Purely combinational.
module ecc_syndrome_decode
    import nand_ecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int BYTE_AW      = $clog2(SECTOR_BYTES),
    parameter int GW           = BYTE_AW + BIT_AW
) (
    input  logic [2*GW-1:0]    syn,
    output ecc_result_e        kind,
    output logic [BYTE_AW-1:0] byte_idx,
    output logic [BIT_AW-1:0]  bit_idx
);

    localparam logic [BYTE_AW:0] SB = SECTOR_BYTES[BYTE_AW:0];

    logic [GW-1:0] lo_half, hi_half;

    assign lo_half  = syn[GW-1:0];
    assign hi_half  = syn[2*GW-1:GW];
    assign byte_idx = hi_half[GW-1:BIT_AW];
    assign bit_idx  = hi_half[BIT_AW-1:0];

    // Decide the outcome from the syndrome shape.
    always_comb begin
        if (syn == '0) begin
            kind = ECC_CLEAN;
        end else if ((lo_half ^ hi_half) == {GW{1'b1}}) begin
            kind = ({1'b0, byte_idx} < SB) ? ECC_DATA_FIXED : ECC_UNCORR;
        end else if ($onehot(syn)) begin
            kind = ECC_CODE_FIXED;
        end else begin
            kind = ECC_UNCORR;
        end
    end

endmodule

// File: rtl/ecc_fix_ctrl.sv
// Sequences a check: latches the syndrome, waits one cycle for the decode,
// then either reports at once or repairs one buffer byte by read-modify-write.
// Assumes the buffer returns read data one cycle after buf_rd_en.
module ecc_fix_ctrl
    import nand_ecc_pkg::*;
#(
    parameter int BYTE_AW = 9,
    parameter int CW      = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               check,
    input  logic [CW-1:0]      syn_in,
    output logic [CW-1:0]      syn_q,
    input  ecc_result_e        kind,
    input  logic [BYTE_AW-1:0] byte_idx,
    input  logic [BIT_AW-1:0]  bit_idx,
    output logic               buf_rd_en,
    output logic               buf_wr_en,
    output logic [BYTE_AW-1:0] buf_addr,
    output logic [7:0]         buf_wdata,
    input  logic [7:0]         buf_rdata,
    output logic               done,
    output ecc_result_e        result,
    output logic [BYTE_AW-1:0] err_byte,
    output logic [BIT_AW-1:0]  err_bit
);

    typedef enum logic [1:0] {ST_IDLE, ST_DECIDE, ST_PATCH} fix_state_e;

    fix_state_e state_q;

    // Step the check sequence and register the reported outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            syn_q    <= '0;
            done     <= 1'b0;
            result   <= ECC_CLEAN;
            err_byte <= '0;
            err_bit  <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: if (check) begin
                    syn_q   <= syn_in;
                    state_q <= ST_DECIDE;
                end
                ST_DECIDE: if (kind == ECC_DATA_FIXED) begin
                    state_q <= ST_PATCH;
                end else begin
                    done     <= 1'b1;
                    result   <= kind;
                    err_byte <= '0;
                    err_bit  <= '0;
                    state_q  <= ST_IDLE;
                end
                ST_PATCH: begin
                    done     <= 1'b1;
                    result   <= ECC_DATA_FIXED;
                    err_byte <= byte_idx;
                    err_bit  <= bit_idx;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the buffer port for the read and the write-back.
    always_comb begin
        buf_rd_en = (state_q == ST_DECIDE) && (kind == ECC_DATA_FIXED);
        buf_wr_en = (state_q == ST_PATCH);
        buf_addr  = byte_idx;
        buf_wdata = buf_rdata ^ (8'h01 << bit_idx);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R10
    AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $past(buf_rd_en));  // R7
    AST_ONE_BIT_PATCH: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> ($countones(buf_wdata ^ buf_rdata) == 1));  // R7
    AST_DONE_AFTER_PATCH: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |=> (done && result == ECC_DATA_FIXED));  // R7
    AST_FIELDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != ECC_DATA_FIXED) |-> (err_byte == '0 && err_bit == '0));  // R11

endmodule

// File: rtl/nand_hamming_ecc.sv
// Top: streams a sector through the parity accumulator, presents the
// inverted packed code, and on check classifies and repairs single-bit errors.
module nand_hamming_ecc
    import nand_ecc_pkg::*;
#(
    parameter int  SECTOR_BYTES = 512,
    localparam int BYTE_AW      = $clog2(SECTOR_BYTES),
    localparam int GW           = BYTE_AW + BIT_AW,
    localparam int CW           = 2 * GW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    output logic [CW-1:0]      code_out,
    input  logic               check,
    input  logic [CW-1:0]      stored_code,
    output logic               done,
    output logic [1:0]         result,
    output logic [BYTE_AW-1:0] err_byte,
    output logic [BIT_AW-1:0]  err_bit,
    output logic               buf_rd_en,
    output logic               buf_wr_en,
    output logic [BYTE_AW-1:0] buf_addr,
    output logic [7:0]         buf_wdata,
    input  logic [7:0]         buf_rdata
);

    logic [GW-1:0]      ones_par, zeros_par;
    logic [CW-1:0]      syn_now, syn_q;
    ecc_result_e        kind, res_e;
    logic [BYTE_AW-1:0] byte_idx;
    logic [BIT_AW-1:0]  bit_idx;

    ecc_parity_acc #(
        .SECTOR_BYTES(SECTOR_BYTES), .BYTE_AW(BYTE_AW), .GW(GW)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_valid(in_valid), .in_byte(in_byte),
        .ones_par(ones_par), .zeros_par(zeros_par)
    );

    // High group above low group, inverted so an erased sector reads all ones.
    assign code_out = ~{ones_par, zeros_par};
    assign syn_now  = code_out ^ stored_code;

    ecc_fix_ctrl #(.BYTE_AW(BYTE_AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .check(check),
        .syn_in(syn_now), .syn_q(syn_q),
        .kind(kind), .byte_idx(byte_idx), .bit_idx(bit_idx),
        .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .done(done), .result(res_e), .err_byte(err_byte), .err_bit(err_bit)
    );

    ecc_syndrome_decode #(
        .SECTOR_BYTES(SECTOR_BYTES), .BYTE_AW(BYTE_AW), .GW(GW)
    ) u_dec (
        .syn(syn_q), .kind(kind), .byte_idx(byte_idx), .bit_idx(bit_idx)
    );

    assign result = res_e;

    AST_NO_BUF_WHEN_REPORTING: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_e != ECC_DATA_FIXED) |-> !$past(buf_wr_en));  // R8
    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_rd_en && buf_wr_en));  // R7

endmodule

// File: tb/test_nand_hamming_ecc.sv
module test_nand_hamming_ecc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic [23:0] code_out;
    logic        check = 1'b0;
    logic [23:0] stored_code = '0;
    logic        done;
    logic [1:0]  result;
    logic [8:0]  err_byte;
    logic [2:0]  err_bit;
    logic        buf_rd_en, buf_wr_en;
    logic [8:0]  buf_addr;
    logic [7:0]  buf_wdata;
    logic [7:0]  buf_rdata = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int wr_count = 0;
    bit finished = 1'b0;

    logic [7:0] mem  [0:511];
    logic [7:0] orig [0:511];

    always #4 clk = ~clk;  // 125 MHz

    nand_hamming_ecc i_nand_hamming_ecc (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_byte(in_byte), .code_out(code_out), .check(check),
        .stored_code(stored_code), .done(done), .result(result),
        .err_byte(err_byte), .err_bit(err_bit), .buf_rd_en(buf_rd_en),
        .buf_wr_en(buf_wr_en), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata)
    );

    // Sector buffer model with one cycle of read latency.
    always @(posedge clk) begin
        if (buf_rd_en) buf_rdata <= mem[buf_addr];
        if (buf_wr_en) begin
            mem[buf_addr] <= buf_wdata;
            wr_count <= wr_count + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference code from the requirement: address parity per group, inverted.
    function automatic logic [23:0] model_code();
        logic [11:0] o, z, a;
        o = '0; z = '0;
        for (int b = 0; b < 512; b++) begin
            for (int i = 0; i < 8; i++) begin
                if (mem[b][i]) begin
                    a = {b[8:0], i[2:0]};
                    for (int k = 0; k < 12; k++) begin
                        if (a[k]) o[k] = ~o[k];
                        else      z[k] = ~z[k];
                    end
                end
            end
        end
        return ~{o, z};
    endfunction

    task automatic stream_junk(input int n);
        for (int b = 0; b < n; b++) begin
            in_valid = 1'b1;
            in_byte  = 8'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic stream_sector();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int b = 0; b < 512; b++) begin
            if ($urandom % 5 == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_byte  = mem[b];
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic fill_random();
        for (int b = 0; b < 512; b++) begin
            orig[b] = 8'($urandom);
            mem[b]  = orig[b];
        end
    endtask

    // Pulse check and measure latency to done; verify the outcome.
    task automatic run_check(input logic [23:0] stored, input int exp_res,
                             input int exp_byte, input int exp_bit,
                             input int exp_lat, input string req);
        int lat;
        int wr0;
        wr0 = wr_count;
        stored_code = stored;
        check = 1'b1;
        @(negedge clk);
        check = 1'b0;
        lat = 1;
        while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == exp_lat, req, "done latency", lat, exp_lat);
        chk(result == 2'(exp_res), req, "result", int'(result), exp_res);
        chk(err_byte == 9'(exp_byte) && err_bit == 3'(exp_bit), "R11",
            "err byte/bit", {err_byte, err_bit}, {exp_byte[8:0], exp_bit[2:0]});
        chk(wr_count - wr0 == (exp_res == 1 ? 1 : 0), req, "buffer writes",
            wr_count - wr0, (exp_res == 1 ? 1 : 0));
        @(negedge clk);
        chk(!done, "R10", "done after pulse", int'(done), 0);
        chk(result == 2'(exp_res), "R10", "result held", int'(result), exp_res);
    endtask

    initial begin
        logic [23:0] c0;
        void'($urandom(32'h5EED_0ECC));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(code_out == 24'hFFFFFF && !done && result == 2'd0, "R1",
            "reset outputs", code_out, 24'hFFFFFF);
        rst_n = 1'b1;
        @(negedge clk);
        chk(code_out == 24'hFFFFFF && !buf_rd_en && !buf_wr_en && !done, "R1",
            "after release", code_out, 24'hFFFFFF);

        // R5: erased sector, then a clean check (R6)
        for (int b = 0; b < 512; b++) mem[b] = 8'hFF;
        stream_sector();
        chk(code_out == 24'hFFFFFF, "R5", "erased code", code_out, 24'hFFFFFF);
        run_check(24'hFFFFFF, 0, 0, 0, 2, "R6");

        // R2: random sectors and sparse patterns
        for (int t = 0; t < 4; t++) begin
            fill_random();
            stream_sector();
            chk(code_out == model_code(), "R2", "random code", code_out, model_code());
        end
        for (int b = 0; b < 512; b++) mem[b] = 8'h00;
        mem[511] = 8'h80;
        stream_sector();
        chk(code_out == model_code(), "R2", "last bit only", code_out, model_code());
        mem[511] = 8'h00; mem[0] = 8'h01; mem[300] = 8'h5A;
        stream_sector();
        chk(code_out == model_code(), "R2", "sparse bits", code_out, model_code());
        run_check(model_code(), 0, 0, 0, 2, "R6");

        // R3: junk before a restart has no effect
        fill_random();
        start = 1'b1; @(negedge clk); start = 1'b0;
        stream_junk(100);
        stream_sector();
        chk(code_out == model_code(), "R3", "restart clears", code_out, model_code());

        // R4: bytes past the sector end are ignored
        stream_junk(7);
        @(negedge clk);
        chk(code_out == model_code(), "R4", "extra bytes", code_out, model_code());

        // R7: single data-bit flips, directed corners then random places
        for (int t = 0; t < 6; t++) begin
            int fb, fi;
            fb = (t == 0) ? 0 : (t == 1) ? 511 : int'($urandom % 512);
            fi = (t == 0) ? 0 : (t == 1) ? 7 : int'($urandom % 8);
            fill_random();
            c0 = model_code();
            mem[fb][fi] = ~mem[fb][fi];
            stream_sector();
            run_check(c0, 1, fb, fi, 3, "R7");
            chk(mem[fb] == orig[fb], "R7", "byte repaired", mem[fb], orig[fb]);
        end

        // R8: single flipped bit in the stored code
        for (int t = 0; t < 4; t++) begin
            int j;
            j = (t == 0) ? 0 : (t == 1) ? 23 : int'($urandom % 24);
            fill_random();
            c0 = model_code();
            stream_sector();
            run_check(c0 ^ (24'h1 << j), 2, 0, 0, 2, "R8");
            chk(mem[5] == orig[5], "R8", "data untouched", mem[5], orig[5]);
        end

        // R9: two data flips and a two-bit code pattern
        for (int t = 0; t < 3; t++) begin
            int b1, b2;
            fill_random();
            c0 = model_code();
            b1 = int'($urandom % 256);
            b2 = 256 + int'($urandom % 256);
            mem[b1][1] = ~mem[b1][1];
            mem[b2][6] = ~mem[b2][6];
            stream_sector();
            run_check(c0, 3, 0, 0, 2, "R9");
            chk(mem[b1] != orig[b1], "R9", "no repair", mem[b1], orig[b1] ^ 8'h02);
        end
        fill_random();
        stream_sector();
        run_check(model_code() ^ 24'h000003, 3, 0, 0, 2, "R9");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule